// File: doc/BRIEF.md
# Victim Line Buffer for a Direct-Mapped Cache

This block is a small, fully associative store that sits next to a direct-mapped first-level cache. It keeps the lines that the cache throws out. Each address has only one home slot in the primary cache, so two hot lines that share a slot keep pushing each other out. The buffer catches every discarded line, which gives those crowded sets extra associativity.

When the primary cache misses, it presents the wanted line address on the lookup port. It also presents the line that currently sits in the home slot. Every valid entry of the buffer compares its full line address (tag and index together) with the request, all in parallel.

- **Hit:** the buffer returns the stored data and dirty bit. The displaced primary line moves into the same slot in the same operation, and the next level is never asked.
- **Miss:** a one-cycle next-level request carries the address outward. The primary cache later places the refilled line into its slot, and the old line comes back to this block through the eviction port.
- **Insertion order:** new victims go into the slots in strict insertion order. The oldest insertion is overwritten first. If the overwritten line was dirty, a writeback is raised with its address and data.

Top module: `victim_cache`

## Requirements
- R1: After reset every entry is invalid, and respValid, nextReqValid and wbValid are 0. A lookup made before any eviction misses.
- R2: A line taken in on the eviction port can be found by a later lookup of the same line address. The hit returns the data and dirty bit that were given at eviction.
- R3: A lookup presented in cycle t gives respValid=1 in cycle t+1, with respHit set to whether some valid entry held the requested address.
- R4: A lookup miss raises nextReqValid for exactly one cycle, together with the response, and nextReqAddr equals the looked-up address. A hit never raises nextReqValid.
- R5: On a hit with dispValid=1, the displaced line (address, data, dirty bit) is stored in the slot of the hit entry. A later lookup of the displaced address hits, and a repeat lookup of the hit address misses.
- R6: On a hit with dispValid=0, the hit entry becomes invalid and nothing takes its place.
- R7: Evictions fill the slots in round-robin order starting from slot 0 after reset, whether or not a slot is valid. Once ENTRIES evictions have been made, the next one overwrites the line inserted earliest. A line swapped in on a hit keeps the insertion age of its slot.
- R8: When an eviction overwrites a valid dirty entry, wbValid=1 in the next cycle, with wbAddr and wbData of the overwritten line. Overwriting a clean or invalid entry gives wbValid=0.
- R9: Matching uses all ADDR_W bits of the line address. Two addresses that differ only in the top (tag) bits never match each other.
- R10: ENTRIES is either 4 or 8. Any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| evictValid | input | 1 | A line discarded by the primary cache is presented |
| evictAddr | input | ADDR_W | Line address of the discarded line |
| evictData | input | DATA_W | Data of the discarded line |
| evictDirty | input | 1 | Discarded line is modified |
| lookupValid | input | 1 | Primary cache missed; search the buffer (never together with evictValid) |
| lookupAddr | input | ADDR_W | Line address being searched |
| dispValid | input | 1 | The home slot of lookupAddr holds a valid line |
| dispAddr | input | ADDR_W | Line address of the line in the home slot |
| dispData | input | DATA_W | Data of the line in the home slot |
| dispDirty | input | 1 | Line in the home slot is modified |
| respValid | output | 1 | Lookup response, one cycle after lookupValid |
| respHit | output | 1 | The lookup found its line |
| respData | output | DATA_W | Data of the found line |
| respDirty | output | 1 | Dirty bit of the found line |
| nextReqValid | output | 1 | One-cycle request to the next level after a miss |
| nextReqAddr | output | ADDR_W | Line address to fetch from the next level |
| wbValid | output | 1 | A dirty line was pushed out of the buffer |
| wbAddr | output | ADDR_W | Line address of the pushed-out line |
| wbData | output | DATA_W | Data of the pushed-out line |

## Verification
The hardest state to reach from the ports is a full buffer in which some slots were refilled by swaps. In that state, the next overwrite target is set by insertion order and not by which slots were touched last, and the dirty bit of a swapped-in line must survive until that line is pushed out. Directed sequences first fill the buffer past its depth, swap lines in with mixed dirty bits, and then evict again. A long seeded random run then mixes lookups and evictions over a small address pool. The small pool keeps hits, swaps and dirty overwrites frequent, and a bench model predicts every response and writeback.

// File: rtl/vc_pkg.sv
package vc_pkg;

  // Strobes from the control to the datapath for one cycle.
  typedef struct packed {
    logic insert;    // write the evicted line into the slot at the write pointer
    logic lookup;    // a lookup is answered at the next edge
    logic hit;       // the lookup found a matching entry
    logic swapFill;  // the displaced primary line takes the hit slot
  } vcStrobe_t;

endpackage

// File: rtl/victim_ctrl.sv
module victim_ctrl
  import vc_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evictValid,
  input  logic               lookupValid,
  input  logic               dispValid,
  input  logic [ENTRIES-1:0] matchVec,
  output vcStrobe_t          strobe,
  output logic [IDX_W-1:0]   hitIdx,
  output logic [IDX_W-1:0]   wrPtr
);

  logic hitAny;

  assign hitAny = |matchVec;

  always_comb begin
    hitIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (matchVec[i]) hitIdx = IDX_W'(i);
    end
  end

  // A lookup takes priority; the caller never overlaps the two ports.
  always_comb begin
    strobe.lookup   = lookupValid;
    strobe.hit      = lookupValid & hitAny;
    strobe.swapFill = lookupValid & hitAny & dispValid;
    strobe.insert   = evictValid & ~lookupValid;
  end

  // Insertion pointer: round robin gives oldest-first replacement.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrPtr <= '0;
    end else if (strobe.insert) begin
      if (wrPtr == IDX_W'(ENTRIES - 1)) wrPtr <= '0;
      else                              wrPtr <= wrPtr + 1'b1;
    end
  end

  a_r7_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.insert |=> wrPtr == IDX_W'($past(wrPtr) + 1'b1));

  a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.insert |=> $stable(wrPtr));

endmodule

// File: rtl/victim_dp.sv
module victim_dp
  import vc_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 32,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  vcStrobe_t          strobe,
  input  logic [IDX_W-1:0]   hitIdx,
  input  logic [IDX_W-1:0]   wrPtr,
  input  logic               evictValid,
  input  logic [ADDR_W-1:0]  evictAddr,
  input  logic [DATA_W-1:0]  evictData,
  input  logic               evictDirty,
  input  logic               lookupValid,
  input  logic [ADDR_W-1:0]  lookupAddr,
  input  logic               dispValid,
  input  logic [ADDR_W-1:0]  dispAddr,
  input  logic [DATA_W-1:0]  dispData,
  input  logic               dispDirty,
  output logic [ENTRIES-1:0] matchVec,
  output logic               respValid,
  output logic               respHit,
  output logic [DATA_W-1:0]  respData,
  output logic               respDirty,
  output logic               nextReqValid,
  output logic [ADDR_W-1:0]  nextReqAddr,
  output logic               wbValid,
  output logic [ADDR_W-1:0]  wbAddr,
  output logic [DATA_W-1:0]  wbData
);

  logic [ENTRIES-1:0] entValid;
  logic [ENTRIES-1:0] entDirty;
  logic [ADDR_W-1:0]  entAddr [ENTRIES];
  logic [DATA_W-1:0]  entData [ENTRIES];

  // Full-address comparators, one per entry.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign matchVec[g] = entValid[g] && (entAddr[g] == lookupAddr);
  end

  // Entry storage.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entValid <= '0;
      entDirty <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        entAddr[i] <= '0;
        entData[i] <= '0;
      end
    end else if (strobe.insert) begin
      entValid[wrPtr] <= 1'b1;
      entDirty[wrPtr] <= evictDirty;
      entAddr[wrPtr]  <= evictAddr;
      entData[wrPtr]  <= evictData;
    end else if (strobe.hit) begin
      entValid[hitIdx] <= strobe.swapFill;
      entDirty[hitIdx] <= strobe.swapFill & dispDirty;
      if (strobe.swapFill) begin
        entAddr[hitIdx] <= dispAddr;
        entData[hitIdx] <= dispData;
      end
    end
  end

  // Registered lookup response and next-level request.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      respValid    <= 1'b0;
      respHit      <= 1'b0;
      respData     <= '0;
      respDirty    <= 1'b0;
      nextReqValid <= 1'b0;
      nextReqAddr  <= '0;
    end else begin
      respValid    <= strobe.lookup;
      respHit      <= strobe.hit;
      respData     <= strobe.hit ? entData[hitIdx] : '0;
      respDirty    <= strobe.hit & entDirty[hitIdx];
      nextReqValid <= strobe.lookup & ~strobe.hit;
      nextReqAddr  <= (strobe.lookup & ~strobe.hit) ? lookupAddr : '0;
    end
  end

  // Writeback of a dirty line pushed out by an insertion.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wbValid <= 1'b0;
      wbAddr  <= '0;
      wbData  <= '0;
    end else begin
      wbValid <= strobe.insert & entValid[wrPtr] & entDirty[wrPtr];
      wbAddr  <= entAddr[wrPtr];
      wbData  <= entData[wrPtr];
    end
  end

  a_r9_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(matchVec));

  a_r3_resp_next: assert property (@(posedge clk) disable iff (!rst_n)
    lookupValid |=> respValid);

  a_r4_req_xor_hit: assert property (@(posedge clk) disable iff (!rst_n)
    respValid |-> (respHit != nextReqValid));

  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.insert |=> entValid[$past(wrPtr)] && entAddr[$past(wrPtr)] == $past(evictAddr));

  a_r6_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.hit && !dispValid) |=> !entValid[$past(hitIdx)]);

  a_r8_wb_source: assert property (@(posedge clk) disable iff (!rst_n)
    wbValid |-> $past(evictValid));

endmodule

// File: rtl/victim_cache.sv
module victim_cache
  import vc_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evictValid,
  input  logic [ADDR_W-1:0] evictAddr,
  input  logic [DATA_W-1:0] evictData,
  input  logic              evictDirty,
  input  logic              lookupValid,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  logic              dispValid,
  input  logic [ADDR_W-1:0] dispAddr,
  input  logic [DATA_W-1:0] dispData,
  input  logic              dispDirty,
  output logic              respValid,
  output logic              respHit,
  output logic [DATA_W-1:0] respData,
  output logic              respDirty,
  output logic              nextReqValid,
  output logic [ADDR_W-1:0] nextReqAddr,
  output logic              wbValid,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [DATA_W-1:0] wbData
);

  localparam int IDX_W = $clog2(ENTRIES);

  // R10: only the two supported depths elaborate.
  if (!(ENTRIES == 4 || ENTRIES == 8)) begin : g_bad_depth
    $error("victim_cache: ENTRIES must be 4 or 8");
  end

  vcStrobe_t          strobe;
  logic [IDX_W-1:0]   hitIdx;
  logic [IDX_W-1:0]   wrPtr;
  logic [ENTRIES-1:0] matchVec;

  victim_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .evictValid  (evictValid),
    .lookupValid (lookupValid),
    .dispValid   (dispValid),
    .matchVec    (matchVec),
    .strobe      (strobe),
    .hitIdx      (hitIdx),
    .wrPtr       (wrPtr)
  );

  victim_dp #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe       (strobe),
    .hitIdx       (hitIdx),
    .wrPtr        (wrPtr),
    .evictValid   (evictValid),
    .evictAddr    (evictAddr),
    .evictData    (evictData),
    .evictDirty   (evictDirty),
    .lookupValid  (lookupValid),
    .lookupAddr   (lookupAddr),
    .dispValid    (dispValid),
    .dispAddr     (dispAddr),
    .dispData     (dispData),
    .dispDirty    (dispDirty),
    .matchVec     (matchVec),
    .respValid    (respValid),
    .respHit      (respHit),
    .respData     (respData),
    .respDirty    (respDirty),
    .nextReqValid (nextReqValid),
    .nextReqAddr  (nextReqAddr),
    .wbValid      (wbValid),
    .wbAddr       (wbAddr),
    .wbData       (wbData)
  );

endmodule

// File: tb/sim_victim_cache.sv
`timescale 1ns/1ps
module sim_victim_cache;

  localparam int N  = 8;
  localparam int AW = 20;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evictValid = 1'b0, evictDirty = 1'b0;
  logic [AW-1:0] evictAddr = '0;
  logic [DW-1:0] evictData = '0;
  logic lookupValid = 1'b0, dispValid = 1'b0, dispDirty = 1'b0;
  logic [AW-1:0] lookupAddr = '0, dispAddr = '0;
  logic [DW-1:0] dispData = '0;
  logic respValid, respHit, respDirty, nextReqValid, wbValid;
  logic [DW-1:0] respData, wbData;
  logic [AW-1:0] nextReqAddr, wbAddr;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  // Bench reference model of the buffer contents.
  logic          mV [N];
  logic          mDt[N];
  logic [AW-1:0] mA [N];
  logic [DW-1:0] mD [N];
  int            mPtr;

  always #2 clk = ~clk;

  victim_cache #(.ENTRIES(N), .ADDR_W(AW), .DATA_W(DW)) u0 (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not end, actual=%0d cycles expected<150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int mFind(input logic [AW-1:0] a);
    for (int i = 0; i < N; i++) if (mV[i] && mA[i] == a) return i;
    return -1;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < N; i++) begin
      mV[i] = 1'b0; mDt[i] = 1'b0; mA[i] = '0; mD[i] = '0;
    end
    mPtr = 0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    modelReset();
  endtask

  // R7/R8: insertion at the model pointer; dirty overwritten line written back.
  task automatic doEvict(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic dt);
    logic expWb;
    logic [AW-1:0] expA;
    logic [DW-1:0] expD;
    expWb = mV[mPtr] && mDt[mPtr];
    expA = mA[mPtr];
    expD = mD[mPtr];
    mV[mPtr] = 1'b1; mDt[mPtr] = dt; mA[mPtr] = a; mD[mPtr] = d;
    mPtr = (mPtr + 1) % N;
    evictValid = 1'b1; evictAddr = a; evictData = d; evictDirty = dt;
    @(negedge clk);
    evictValid = 1'b0;
    chk("R8", "wbValid", 64'(wbValid), 64'(expWb));
    if (expWb) begin
      chk("R8", "wbAddr", 64'(wbAddr), 64'(expA));
      chk("R8", "wbData", 64'(wbData), 64'(expD));
    end
    chk("R3", "no resp on evict", 64'(respValid), 64'd0);
  endtask

  // R2-R6: lookup, response one cycle later, swap or drop on hit.
  task automatic doLookup(input logic [AW-1:0] a, input logic dv, input logic [AW-1:0] da,
                          input logic [DW-1:0] dd, input logic ddt);
    int idx;
    logic [DW-1:0] expD;
    logic expDt;
    idx = mFind(a);
    expD = (idx >= 0) ? mD[idx] : '0;
    expDt = (idx >= 0) ? mDt[idx] : 1'b0;
    if (idx >= 0) begin
      mV[idx] = dv; mDt[idx] = dv & ddt;
      if (dv) begin mA[idx] = da; mD[idx] = dd; end
    end
    lookupValid = 1'b1; lookupAddr = a;
    dispValid = dv; dispAddr = da; dispData = dd; dispDirty = ddt;
    @(negedge clk);
    lookupValid = 1'b0; dispValid = 1'b0;
    chk("R3", "respValid", 64'(respValid), 64'd1);
    chk("R3", "respHit", 64'(respHit), 64'(idx >= 0));
    chk("R4", "nextReqValid", 64'(nextReqValid), 64'(idx < 0));
    if (idx >= 0) begin
      chk("R2", "respData", 64'(respData), 64'(expD));
      chk("R2", "respDirty", 64'(respDirty), 64'(expDt));
    end else begin
      chk("R4", "nextReqAddr", 64'(nextReqAddr), 64'(a));
    end
    chk("R8", "no wb on lookup", 64'(wbValid), 64'd0);
  endtask

  task automatic idleCheck();
    @(negedge clk);
    chk("R4", "request one cycle only", 64'(nextReqValid), 64'd0);
    chk("R3", "resp one cycle only", 64'(respValid), 64'd0);
  endtask

  function automatic logic [AW-1:0] freshAddr();
    logic [AW-1:0] a;
    do a = AW'($urandom_range(0, 23)) | {($urandom_range(0, 1) == 1), {(AW-1){1'b0}}};
    while (mFind(a) >= 0);
    return a;
  endfunction

  initial begin
    void'($urandom(32'd4242));
    modelReset();
    doReset();

    // R1: reset state
    chk("R1", "respValid", 64'(respValid), 64'd0);
    chk("R1", "nextReqValid", 64'(nextReqValid), 64'd0);
    chk("R1", "wbValid", 64'(wbValid), 64'd0);
    doLookup(20'h00010, 1'b0, '0, '0, 1'b0);
    chk("R1", "empty lookup misses", 64'(respHit), 64'd0);
    idleCheck();

    // R2: capture and find again
    doEvict(20'h00005, 32'hA5A5_0001, 1'b1);
    doLookup(20'h00005, 1'b0, '0, '0, 1'b0);
    chk("R2", "hit after eviction", 64'(respHit), 64'd1);

    // R6: hit without displaced line drops the entry
    doLookup(20'h00005, 1'b0, '0, '0, 1'b0);
    chk("R6", "dropped entry misses", 64'(respHit), 64'd0);

    // R9: same low bits, different tag
    doEvict(20'h00007, 32'h0000_0777, 1'b0);
    doLookup(20'h80007, 1'b0, '0, '0, 1'b0);
    chk("R9", "tag differs -> miss", 64'(respHit), 64'd0);

    // R5: swap on hit
    doLookup(20'h00007, 1'b1, 20'h00017, 32'h1717_1717, 1'b1);
    chk("R5", "swap hit", 64'(respHit), 64'd1);
    doLookup(20'h00007, 1'b0, '0, '0, 1'b0);
    chk("R5", "swapped-out line gone", 64'(respHit), 64'd0);
    doLookup(20'h00017, 1'b1, 20'h00027, 32'h2727_2727, 1'b0);
    chk("R5", "displaced line found", 64'(respHit), 64'd1);
    chk("R5", "displaced dirty kept", 64'(respDirty), 64'd1);

    // R7/R8: fill past depth, dirty and clean overwrites
    doReset();
    for (int i = 0; i < N; i++) doEvict(AW'(32 + i), DW'(32'hD000 + i), (i % 2) == 0);
    doEvict(20'h00100, 32'hBEEF, 1'b0);  // overwrites slot 0 (dirty)
    chk("R7", "oldest overwritten", 64'(mFind(AW'(32))), 64'hFFFF_FFFF_FFFF_FFFF);
    doEvict(20'h00101, 32'hBEF0, 1'b0);  // overwrites slot 1 (clean): no wb
    doLookup(AW'(32), 1'b0, '0, '0, 1'b0);
    chk("R7", "first insertion evicted", 64'(respHit), 64'd0);
    doLookup(AW'(34), 1'b1, 20'h00200, 32'h5A5A, 1'b1);
    chk("R7", "third insertion still present", 64'(respHit), 64'd1);
    doEvict(20'h00102, 32'hBEF1, 1'b0);  // slot 2 now holds swapped dirty line
    chk("R7", "swapped line keeps slot age", 64'(mFind(20'h00200)), 64'hFFFF_FFFF_FFFF_FFFF);

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 1) == 0) begin
        logic [AW-1:0] ea;
        ea = freshAddr();
        doEvict(ea, $urandom(), 1'($urandom_range(0, 1)));
      end else begin
        logic [AW-1:0] la, da;
        la = AW'($urandom_range(0, 23)) | {($urandom_range(0, 1) == 1), {(AW-1){1'b0}}};
        da = freshAddr();
        if (da == la) da = da ^ AW'(20'h40000);
        doLookup(la, 1'($urandom_range(0, 3) != 0), da, $urandom(), 1'($urandom_range(0, 1)));
      end
      if ($urandom_range(0, 7) == 0) idleCheck();
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule